// File: doc/BRIEF.md
# Programmable Chip-Select Timing Generator

This block sequences a single external memory access for a general-purpose chip-select engine on a multiplexed address/data bus. A request carries four per-bank timing options and one global divide selector. The options are a 2-bit setup code, an extended-setup flag, a relaxed-timing flag and a wait-state count. The divide selector states how many internal clock ticks make one bus clock cycle. The block runs on the fast internal clock, so it can place the chip-select edge at a quarter-cycle or half-cycle offset inside a bus cycle.

Each access has a fixed order. First comes an address-latch phase one bus cycle long. Then the chip-select setup delay runs, measured from the moment the latched address becomes valid. Then comes an active span that holds chip select and, for writes, a write-enable window nested strictly inside it. A one-tick completion pulse marks the last tick of chip select. Every edge time is a count of internal ticks. It is built from whole bus cycles plus a quarter or half of the divide ratio.

The request side is a valid/ready handshake. Ready is high only while the sequencer is idle. A request is taken on a clock edge where valid and ready are both high. While ready is low, valid is ignored and the request fields may change freely. All option fields and the divide selector are captured at acceptance and held for the whole access.

Top module: `chipsel_timing`

## Requirements
- R1: During and straight after reset, req_ready is 1 and ale, cs, we and done are 0.
- R2: req_ready is 1 only while idle. A request is taken on an edge with req_valid and req_ready both high. Fields are captured at that edge, and changes to the fields or to req_valid during an access have no effect on it.
- R3: ale is high for exactly D ticks, starting in the cycle after acceptance. cs is never high in the same cycle as ale.
- R4: div_sel gives D, the ticks per bus cycle: 0 gives 2, 1 gives 4, 2 and 3 give 8.
- R5: Setup code 00 raises cs in the first tick after ale falls, which is an offset of 0 ticks.
- R6: With the extended flag clear, setup code 10 gives an offset of D/4 ticks when D is 4 or 8, and 1 tick (a half cycle) when D is 2. Code 01 behaves as code 10 in every case.
- R7: With the extended flag clear, setup code 11 gives an offset of D/2 ticks.
- R8: With the extended flag set, code 11 gives 2·D ticks. Code 10 (and 01) gives D ticks when D is 4 and 2·D ticks otherwise, so an offset is never earlier than requested.
- R9: cs stays high for D·(2+W) consecutive ticks. W is the wait-state count, or twice that count when the relaxed flag is set.
- R10: For a write (req_wr=1), we rises one tick after cs rises and falls one tick before cs falls. For a read, we stays 0.
- R11: done is a one-tick pulse in the last tick that cs is high. req_ready returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, D times the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_acs | input | 2 | Chip-select setup code |
| req_xacs | input | 1 | Extended setup flag |
| req_trlx | input | 1 | Relaxed timing flag, doubles wait states |
| req_scy | input | SCY_W | Wait-state count in bus cycles |
| req_wr | input | 1 | Access is a write |
| div_sel | input | 2 | Internal-to-bus clock ratio selector |
| ale | output | 1 | Address latch enable |
| cs | output | 1 | Chip select, active high |
| we | output | 1 | Write enable, active high |
| done | output | 1 | Last tick of the access |

## Verification
The bench sweeps every setup code, both flags, every divide selector and several wait counts, for both reads and writes. It compares every tick of ale, cs, we and done against edge times it computes itself. The hardest cases are the offsets that cannot be resolved at a ratio of 2 and the one-cycle extended setting at ratios other than 4. A design that got them wrong would raise cs early or overlap it with ale, and the cs rising edge would land on the wrong tick. The bench changes the fields and pulses valid during a busy access. A design that sampled the fields late, or took a request while busy, would show a changed span or a duplicate ale. The longest span with relaxed timing and the largest wait count tests counter width. A zero-wait access at ratio 2 tests that we still nests inside cs.

// File: rtl/chipsel_pkg.sv
package chipsel_pkg;
  localparam int DIV_W = 4;  // holds tick counts 2, 4, 8
  localparam int OFS_W = 5;  // largest offset is 2*8 = 16

  typedef enum logic [1:0] {
    SETUP_NONE  = 2'b00,
    SETUP_RSV   = 2'b01,
    SETUP_SHORT = 2'b10,
    SETUP_LONG  = 2'b11
  } setup_e;

  function automatic logic [DIV_W-1:0] ticks_per_cycle(input logic [1:0] sel);
    case (sel)
      2'd0:    ticks_per_cycle = DIV_W'(2);
      2'd1:    ticks_per_cycle = DIV_W'(4);
      default: ticks_per_cycle = DIV_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/cst_offset.sv
module cst_offset
  import chipsel_pkg::*;
(
  input  logic [DIV_W-1:0] d,
  input  setup_e           code,
  input  logic             xsetup,
  output logic [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] d5, quarter, half, twice;

  always_comb begin
    d5      = OFS_W'(d);
    quarter = d5 >> 2;
    half    = d5 >> 1;
    twice   = d5 << 1;
    case (code)
      SETUP_NONE: ofs = '0;
      SETUP_LONG: ofs = xsetup ? twice : half;
      // short and reserved codes: round up to the next legal offset
      default: begin
        if (xsetup) ofs = (d5 == OFS_W'(4)) ? d5 : twice;
        else        ofs = (d5 == OFS_W'(2)) ? half : quarter;
      end
    endcase
  end
endmodule

// File: rtl/cst_span.sv
module cst_span
  import chipsel_pkg::*;
#(
  parameter int SCY_W  = 4,
  parameter int SPAN_W = 9
) (
  input  logic [DIV_W-1:0] d,
  input  logic [SCY_W-1:0] scy,
  input  logic             relaxed,
  output logic [SPAN_W-1:0] span
);
  logic [SPAN_W-1:0] waits;

  always_comb begin
    waits = relaxed ? SPAN_W'({scy, 1'b0}) : SPAN_W'(scy);
    span  = SPAN_W'(d) * (waits + SPAN_W'(2));
  end
endmodule

// File: rtl/cst_seq.sv
module cst_seq #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [CNT_W-1:0] ale_end,
  input  logic [CNT_W-1:0] cs_start,
  input  logic [CNT_W-1:0] cs_end,
  output logic             busy,
  output logic             ale,
  output logic             cs,
  output logic             we,
  output logic             done
);
  logic [CNT_W-1:0] tick;
  logic [CNT_W-1:0] last_tick;

  assign last_tick = cs_end - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tick <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tick <= '0;
    end else if (busy) begin
      if (tick == last_tick) busy <= 1'b0;
      else                   tick <= tick + CNT_W'(1);
    end
  end

  always_comb begin
    ale  = busy && (tick < ale_end);
    cs   = busy && (tick >= cs_start) && (tick < cs_end);
    we   = busy && is_write && (tick > cs_start) && (tick < last_tick);
    done = busy && (tick == last_tick);
  end
endmodule

// File: rtl/chipsel_timing.sv
module chipsel_timing
  import chipsel_pkg::*;
#(
  parameter int SCY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_acs,
  input  logic             req_xacs,
  input  logic             req_trlx,
  input  logic [SCY_W-1:0] req_scy,
  input  logic             req_wr,
  input  logic [1:0]       div_sel,
  output logic             ale,
  output logic             cs,
  output logic             we,
  output logic             done
);
  localparam int MAX_SPAN = 8 * (2 + 2 * ((1 << SCY_W) - 1));
  localparam int SPAN_W   = $clog2(MAX_SPAN + 1);
  localparam int CNT_W    = SPAN_W + 1;

  logic             busy, accept;
  setup_e           code_q;
  logic             xacs_q, trlx_q, wr_q;
  logic [SCY_W-1:0] scy_q;
  logic [1:0]       div_q;
  logic [DIV_W-1:0] d;
  logic [OFS_W-1:0] ofs;
  logic [SPAN_W-1:0] span;
  logic [CNT_W-1:0] ale_end, cs_start, cs_end;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= SETUP_NONE;
      xacs_q <= 1'b0;
      trlx_q <= 1'b0;
      wr_q   <= 1'b0;
      scy_q  <= '0;
      div_q  <= 2'd0;
    end else if (accept) begin
      code_q <= setup_e'(req_acs);
      xacs_q <= req_xacs;
      trlx_q <= req_trlx;
      wr_q   <= req_wr;
      scy_q  <= req_scy;
      div_q  <= div_sel;
    end
  end

  assign d = ticks_per_cycle(div_q);

  cst_offset u_ofs (
    .d      (d),
    .code   (code_q),
    .xsetup (xacs_q),
    .ofs    (ofs)
  );

  cst_span #(.SCY_W(SCY_W), .SPAN_W(SPAN_W)) u_span (
    .d       (d),
    .scy     (scy_q),
    .relaxed (trlx_q),
    .span    (span)
  );

  assign ale_end  = CNT_W'(d);
  assign cs_start = ale_end + CNT_W'(ofs);
  assign cs_end   = cs_start + CNT_W'(span);

  cst_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .is_write (wr_q),
    .ale_end  (ale_end),
    .cs_start (cs_start),
    .cs_end   (cs_end),
    .busy     (busy),
    .ale      (ale),
    .cs       (cs),
    .we       (we),
    .done     (done)
  );
endmodule

// File: rtl/chipsel_timing_chk.sv
module chipsel_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ale,
  input logic cs,
  input logic we,
  input logic done
);
  // R3
  ale_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && cs));

  // R3
  accept_starts_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || cs) |-> !req_ready);

  // R10
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> cs);

  // R10
  we_falls_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cs);

  // R11
  done_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs && !we));

  // R11
  done_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !cs && req_ready));
endmodule

bind chipsel_timing chipsel_timing_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ale       (ale),
  .cs        (cs),
  .we        (we),
  .done      (done)
);

// File: tb/chipsel_timing_tb.sv
module chipsel_timing_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_acs = 2'd0;
  logic       req_xacs = 1'b0;
  logic       req_trlx = 1'b0;
  logic [3:0] req_scy = 4'd0;
  logic       req_wr = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic       ale, cs, we, done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chipsel_timing #(.SCY_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_acs(req_acs), .req_xacs(req_xacs), .req_trlx(req_trlx),
    .req_scy(req_scy), .req_wr(req_wr), .div_sel(div_sel),
    .ale(ale), .cs(cs), .we(we), .done(done)
  );

  function automatic int ticks_of(int sel);
    if (sel == 0) return 2;
    if (sel == 1) return 4;
    return 8;
  endfunction

  function automatic int offset_of(int d, int code, int ext);
    if (code == 0) return 0;
    if (code == 3) return ext ? 2 * d : d / 2;
    if (ext) return (d == 4) ? d : 2 * d;
    return (d == 2) ? 1 : d / 4;
  endfunction

  function automatic string cs_tag(int code, int ext);
    if (code == 0) return "R5 and R9";
    if (ext)       return "R8 and R9";
    if (code == 3) return "R7 and R9";
    return "R6 and R9";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_access(input int sel, input int code, input int ext,
                            input int rel, input int scy, input int wr);
    int d, ofs, span, ale_end, cs_s, cs_e;
    int bad_ale, bad_cs, bad_we, bad_done, bad_rdy;
    int first_ale, first_cs, first_we, first_done, first_rdy;
    d       = ticks_of(sel);
    ofs     = offset_of(d, code, ext);
    span    = d * (2 + (rel ? 2 * scy : scy));
    ale_end = d;
    cs_s    = ale_end + ofs;
    cs_e    = cs_s + span;
    bad_ale = 0; bad_cs = 0; bad_we = 0; bad_done = 0; bad_rdy = 0;
    first_ale = -1; first_cs = -1; first_we = -1; first_done = -1; first_rdy = -1;

    @(negedge clk);
    req_valid = 1'b1;
    req_acs   = 2'(code);
    req_xacs  = 1'(ext);
    req_trlx  = 1'(rel);
    req_scy   = 4'(scy);
    req_wr    = 1'(wr);
    div_sel   = 2'(sel);
    @(posedge clk);
    for (int t = 0; t < cs_e; t++) begin
      @(negedge clk);
      // R2: scramble the request side while busy
      req_valid = (t == 1 || t == 2);
      req_acs   = ~2'(code);
      req_xacs  = ~1'(ext);
      req_trlx  = ~1'(rel);
      req_scy   = ~4'(scy);
      req_wr    = ~1'(wr);
      div_sel   = 2'(sel + 1);
      if (ale !== (t < ale_end)) begin bad_ale++; if (first_ale < 0) first_ale = t; end
      if (cs !== (t >= cs_s && t < cs_e)) begin bad_cs++; if (first_cs < 0) first_cs = t; end
      if (we !== (wr != 0 && t > cs_s && t < cs_e - 1)) begin bad_we++; if (first_we < 0) first_we = t; end
      if (done !== (t == cs_e - 1)) begin bad_done++; if (first_done < 0) first_done = t; end
      if (req_ready !== 1'b0) begin bad_rdy++; if (first_rdy < 0) first_rdy = t; end
    end
    check(bad_ale == 0, "R3 and R4", $sformatf("ale mismatches (first tick %0d) div=%0d", first_ale, sel), bad_ale, 0);
    check(bad_cs == 0, cs_tag(code, ext),
          $sformatf("cs mismatches (first tick %0d) d=%0d code=%0d ext=%0d rel=%0d scy=%0d",
                    first_cs, d, code, ext, rel, scy), bad_cs, 0);
    check(bad_we == 0, "R10", $sformatf("we mismatches (first tick %0d) wr=%0d", first_we, wr), bad_we, 0);
    check(bad_done == 0, "R11", $sformatf("done mismatches (first tick %0d)", first_done), bad_done, 0);
    check(bad_rdy == 0, "R2", $sformatf("ready high while busy (first tick %0d)", first_rdy), bad_rdy, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready === 1'b1 && !ale && !cs && !we && !done, "R11",
          "idle after done (ready, outputs)", int'(req_ready), 1);
  endtask

  initial begin
    #1;
    check(req_ready === 1'b1 && ale === 1'b0 && cs === 1'b0 && we === 1'b0 && done === 1'b0,
          "R1", "state in reset", int'(req_ready), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && ale === 1'b0 && cs === 1'b0 && we === 1'b0 && done === 1'b0,
          "R1", "state after reset", int'({req_ready, ale, cs, we, done}), 16);
    for (int sel = 0; sel < 4; sel++)
      for (int code = 0; code < 4; code++)
        for (int ext = 0; ext < 2; ext++)
          for (int rel = 0; rel < 2; rel++)
            for (int si = 0; si < 3; si++)
              for (int wr = 0; wr < 2; wr++)
                run_access(sel, code, ext, rel, (si == 2) ? 5 : si, wr);
    // longest span: widest counter use
    run_access(2, 3, 1, 1, 15, 1);
    // shortest span at the fastest ratio
    run_access(0, 0, 0, 0, 0, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule